// File: doc/BRIEF.md
# Configurable Parallel-Prefix Adder

This block adds two W-bit unsigned operands and a carry-in. It returns a W-bit sum and a carry-out, registered once at the output. Carries come from a radix-2 generate/propagate prefix network. The network moves carry information from each bit position towards the higher ones. The carry-in enters that network as an extra generate term one position below bit 0.

Two elaboration-time parameters select the structure:

- `TOPO` picks the prefix graph:
  - `TOPO_LF`: a minimum-depth graph with unbounded fanout, where each node at level k merges with the last node of the block below it.
  - `TOPO_KS`: a graph with bounded fanout and more nodes, where each node at level k merges with the node 2^k positions lower.
  - `TOPO_SERIAL`: a ripple chain.
- `SUM` picks how sum bits are formed:
  - `SUM_LOOKAHEAD` XORs each propagate bit with its prefix carry.
  - `SUM_SELECT` precomputes each block's sum for a block carry-in of 0 and of 1. A multiplexer driven by the prefix carry at the block boundary then picks one of the two.

Every configuration uses the same prefix-node function, and every configuration gives the same result bit for bit.

To use the adder as a comparator, drive the second operand with the inverted value of X and set the carry-in. The carry-out is then 1 exactly when A >= X.

Top module: `pp_adder`

## Requirements
- R1: One clock edge after the operands are applied, `sum_o` equals (a_i + b_i + cin_i) mod 2^W.
- R2: One clock edge after the operands are applied, `carry_o` equals bit W of the (W+1)-bit sum a_i + b_i + cin_i.
- R3: The carry-in ripples through a full run of propagate bits. All-ones plus 0 with cin 1 gives sum 0 and carry 1. All-ones plus 1 with cin 0 gives the same result. All-ones plus all-ones with cin 1 gives sum all-ones and carry 1.
- R4: Every combination of `TOPO` (LF, KS, SERIAL) and `SUM` (LOOKAHEAD, SELECT) gives identical outputs for identical inputs. Inside the block, the prefix carry into each bit i+1 equals g[i] | (p[i] & carry into bit i).
- R5: With b_i = ~x and cin_i = 1, `carry_o` is 1 exactly when a_i >= x as unsigned numbers. When a_i == x, `sum_o` is also 0.
- R6: While `rst_ni` is low, `sum_o` and `carry_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | W | Registered sum |
| carry_o | output | 1 | Registered carry-out |

## Verification
All eighteen configurations (three widths, three topologies, two sum schemes) receive the same stream, and each output is scored against an arithmetic model.

| Pattern | What it tells apart |
|---|---|
| Random operands with a random carry-in | Wrong prefix-node pairings in the LF and KS graphs |
| All-ones operands against 0 or 1 | The longest carry chain; a carry-in that is dropped or a block boundary that is misselected |
| Comparator pairs (a equal to x, a just above x, a just below x) | Off-by-one faults in the carry-out |

Comparing the configurations with each other on every sample isolates a fault to a single topology or a single sum scheme.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  typedef enum logic [1:0] {TOPO_LF, TOPO_KS, TOPO_SERIAL} topo_e;
  typedef enum logic {SUM_LOOKAHEAD, SUM_SELECT} sum_e;

  // operands packed as {g, p}; hi covers the upper span
  function automatic logic [1:0] pg_merge(input logic [1:0] hi, input logic [1:0] lo);
    pg_merge = {hi[1] | (hi[0] & lo[1]), hi[0] & lo[0]};
  endfunction
endpackage

// File: rtl/ppa_pg_gen.sv
module ppa_pg_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W:0]   g_o,
  output logic [W:0]   p_o
);
  // position 0 carries cin; bit k of the operands sits at position k+1
  assign g_o = {a_i & b_i, cin_i};
  assign p_o = {a_i ^ b_i, 1'b0};
endmodule

// File: rtl/ppa_prefix_net.sv
module ppa_prefix_net
  import ppa_pkg::*;
#(
  parameter int    N    = 33,
  parameter topo_e TOPO = TOPO_LF
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  output logic [N-1:0] grp_g_o
);
  localparam int L = (N > 1) ? $clog2(N) : 1;

  if (TOPO == TOPO_SERIAL) begin : g_serial
    logic [N-1:0] sg, sp;
    assign sg[0] = g_i[0];
    assign sp[0] = p_i[0];
    for (genvar k = 1; k < N; k++) begin : g_node
      assign {sg[k], sp[k]} = pg_merge({g_i[k], p_i[k]}, {sg[k-1], sp[k-1]});
    end
    logic unused_p;
    assign unused_p = ^sp;
    assign grp_g_o  = sg;
  end else begin : g_tree
    logic [L:0][N-1:0] gl, pl;
    assign gl[0] = g_i;
    assign pl[0] = p_i;
    for (genvar lv = 0; lv < L; lv++) begin : g_lvl
      for (genvar k = 0; k < N; k++) begin : g_node
        if (TOPO == TOPO_LF && ((k >> lv) & 1) == 1) begin : g_lf
          localparam int J = ((k >> lv) << lv) - 1;
          assign {gl[lv+1][k], pl[lv+1][k]} =
            pg_merge({gl[lv][k], pl[lv][k]}, {gl[lv][J], pl[lv][J]});
        end else if (TOPO == TOPO_KS && k >= (1 << lv)) begin : g_ks
          localparam int J = k - (1 << lv);
          assign {gl[lv+1][k], pl[lv+1][k]} =
            pg_merge({gl[lv][k], pl[lv][k]}, {gl[lv][J], pl[lv][J]});
        end else begin : g_pass
          assign gl[lv+1][k] = gl[lv][k];
          assign pl[lv+1][k] = pl[lv][k];
        end
      end
    end
    logic unused_p;
    assign unused_p = ^pl[L];
    assign grp_g_o  = gl[L];
  end
endmodule

// File: rtl/ppa_sum_gen.sv
module ppa_sum_gen
  import ppa_pkg::*;
#(
  parameter int   W    = 32,
  parameter sum_e MODE = SUM_LOOKAHEAD,
  parameter int   BLK  = 4
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o
);
  localparam int NBLK = (W + BLK - 1) / BLK;

  if (MODE == SUM_LOOKAHEAD) begin : g_cla
    logic unused_g;
    assign unused_g = ^g_i;
    assign sum_o    = p_i ^ c_i;
  end else begin : g_csel
    // only block-boundary carries steer the muxes
    logic unused_c;
    assign unused_c = ^c_i;
    for (genvar bk = 0; bk < NBLK; bk++) begin : g_blk
      localparam int LO = bk * BLK;
      localparam int HI = (((LO + BLK) < W) ? (LO + BLK) : W) - 1;
      localparam int BW = HI - LO + 1;
      logic [BW-1:0] s0, s1;
      always_comb begin
        logic r0, r1;
        r0 = 1'b0;
        r1 = 1'b1;
        for (int i = 0; i < BW; i++) begin
          s0[i] = p_i[LO+i] ^ r0;
          s1[i] = p_i[LO+i] ^ r1;
          r0 = g_i[LO+i] | (p_i[LO+i] & r0);
          r1 = g_i[LO+i] | (p_i[LO+i] & r1);
        end
      end
      assign sum_o[HI:LO] = c_i[LO] ? s1 : s0;
    end
  end
endmodule

// File: rtl/pp_adder.sv
module pp_adder
  import ppa_pkg::*;
#(
  parameter int    W       = 32,
  parameter topo_e TOPO    = TOPO_LF,
  parameter sum_e  SUM     = SUM_LOOKAHEAD,
  parameter int    SEL_BLK = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  localparam int N = W + 1;

  logic [W:0]   g_pos, p_pos, grp_g;
  logic [W-1:0] sum_d;

  ppa_pg_gen #(.W(W)) i_pg (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .g_o(g_pos), .p_o(p_pos)
  );

  ppa_prefix_net #(.N(N), .TOPO(TOPO)) i_prefix (
    .g_i(g_pos), .p_i(p_pos), .grp_g_o(grp_g)
  );

  // grp_g[i] is the carry into operand bit i; grp_g[W] is the carry-out
  ppa_sum_gen #(.W(W), .MODE(SUM), .BLK(SEL_BLK)) i_sum (
    .g_i(g_pos[W:1]), .p_i(p_pos[W:1]), .c_i(grp_g[W-1:0]), .sum_o(sum_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      sum_o   <= sum_d;
      carry_o <= grp_g[W];
    end
  end

  // reference model and history flag for the checks below
  logic [W:0] ref_sum;
  logic       past_ok;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_sum_ref_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> sum_o == $past(ref_sum[W-1:0]));

  p_carry_ref_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> carry_o == $past(ref_sum[W]));

  p_cmp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cin_i && b_i == ~a_i) |=> (carry_o && sum_o == '0));

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_chain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_g[i+1] == (g_pos[i+1] | (p_pos[i+1] & grp_g[i])));
  end
endmodule

// File: tb/test_pp_adder.sv
`timescale 1ns/1ps
module test_pp_adder;
  import ppa_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_drv = '0, b_drv = '0;
  logic        cin_drv = 1'b0;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] a, b, x;
    logic        cin;
    int          kind; // 0 random, 1 carry edge, 2 compare
  } item_t;
  item_t sb_q[$];

  logic [32:0] res [3][3][2];

  for (genvar wi = 0; wi < 3; wi++) begin : g_w
    localparam int W = 8 << wi;
    for (genvar ti = 0; ti < 3; ti++) begin : g_t
      for (genvar si = 0; si < 2; si++) begin : g_s
        logic [W-1:0] s;
        logic         c;
        pp_adder #(.W(W), .TOPO(topo_e'(ti)), .SUM(sum_e'(si)), .SEL_BLK(3 + wi)) i_pp_adder (
          .clk_i(clk), .rst_ni(rst_n), .a_i(a_drv[W-1:0]), .b_i(b_drv[W-1:0]),
          .cin_i(cin_drv), .sum_o(s), .carry_o(c)
        );
        assign res[wi][ti][si] = 33'({c, s});
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int w, input int t, input int s,
                       input longint unsigned got, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s w=%0d topo=%0d sum=%0d got=%h exp=%h", tag, w, t, s, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic cin,
                       input int kind, input logic [31:0] x);
    item_t it;
    @(negedge clk);
    a_drv = a; b_drv = b; cin_drv = cin;
    it.a = a; it.b = b; it.cin = cin; it.kind = kind; it.x = x;
    sb_q.push_back(it);
  endtask

  // monitor: output registered on the edge after the negedge drive
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      for (int wi = 0; wi < 3; wi++) begin
        int W;
        longint unsigned m, aw, bw, xw, e, got;
        string ts, tc;
        W  = 8 << wi;
        m  = (64'd1 << W) - 1;
        aw = it.a & m; bw = it.b & m; xw = it.x & m;
        e  = aw + bw + it.cin;
        ts = (it.kind == 1) ? "R3" : "R1";
        tc = (it.kind == 1) ? "R3" : "R2";
        for (int ti = 0; ti < 3; ti++) begin
          for (int si = 0; si < 2; si++) begin
            got = res[wi][ti][si];
            check((got & m) == (e & m), ts, W, ti, si, got & m, e & m);
            check(got[W] == e[W], tc, W, ti, si, got[W], e[W]);
            if (it.kind == 2)
              check(got[W] == (aw >= xw), "R5", W, ti, si, got[W], aw >= xw);
          end
        end
        // R4: every configuration matches the default one
        begin
          bit same;
          same = 1'b1;
          for (int ti = 0; ti < 3; ti++)
            for (int si = 0; si < 2; si++)
              if (res[wi][ti][si] != res[wi][0][0]) same = 1'b0;
          check(same, "R4", W, 0, 0, res[wi][2][1], res[wi][0][0]);
        end
      end
    end
  end

  initial begin
    logic [31:0] x;
    repeat (3) @(negedge clk);
    a_drv = 32'hffff_ffff; b_drv = 32'h1; cin_drv = 1'b1;
    #1;
    // R6: outputs held at zero in reset despite active inputs
    for (int wi = 0; wi < 3; wi++)
      for (int ti = 0; ti < 3; ti++)
        for (int si = 0; si < 2; si++)
          check(res[wi][ti][si] == '0, "R6", 8 << wi, ti, si, res[wi][ti][si], 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 carry-chain edges
    drive(32'hffff_ffff, 32'h0, 1'b1, 1, '0);
    drive(32'hffff_ffff, 32'h1, 1'b0, 1, '0);
    drive(32'hffff_ffff, 32'hffff_ffff, 1'b1, 1, '0);
    drive(32'h0, 32'h0, 1'b0, 1, '0);
    drive(32'h0, 32'h0, 1'b1, 1, '0);

    // R1/R2 random operands
    for (int n = 0; n < 300; n++)
      drive($urandom, $urandom, 1'($urandom), 0, '0);

    // R5 comparator: equal, one above, one below, random
    for (int n = 0; n < 40; n++) begin
      logic [31:0] a;
      a = $urandom;
      x = $urandom;
      case (n % 4)
        0: x = a;
        1: x = a - 1;
        2: x = a + 1;
        default: ;
      endcase
      drive(a, ~x, 1'b1, 2, x);
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule